// File: doc/BRIEF.md
# Dual Hardware Stack Unit

This unit keeps two 16-bit stacks inside the processor core. One is the data stack, used for expression evaluation. The other is the return stack, which is separate from it. Each stack holds its top element in a dedicated register: TOS for the data stack and TOR for the return stack. The remaining entries sit in a small register-file array behind that top register. The array pointers are internal and are never exposed. They wrap modulo the array depth, and no overflow or underflow is ever reported.

A single 4-bit command is applied each clock cycle, together with a 16-bit write value. The commands are:
- push, pop, replace-top and a combined pop-two/push-one on the data stack;
- push and drop on the return stack;
- direct moves of the top element from either stack to the other.

Every command, including the combined one, finishes in one cycle. The outputs TOS, NOS (the entry just below the data top) and TOR show the new state one clock edge after the command is sampled.

Top module: `dual_stack_unit`

## Requirements
- R1: A synchronous active-low reset (rst_n sampled low at a rising edge) zeroes TOS, TOR and both internal pointers.
- R2: Command 1 (data push) loads wdata into TOS and moves the old TOS into NOS in the same cycle.
- R3: Command 2 (data pop) moves NOS into TOS, and the entry below NOS becomes the new NOS.
- R4: Command 3 (replace) loads wdata into TOS and leaves NOS and TOR unchanged.
- R5: Command 4 (pop two, push one) loads wdata into TOS, and the entry that was below the old NOS becomes NOS, in a single cycle.
- R6: Command 5 (data to return) loads the old TOS into TOR and moves the old NOS into TOS.
- R7: Command 6 (return to data) loads the old TOR into TOS, moves the old TOS into NOS, and moves the entry below TOR up into TOR.
- R8: Command 7 pushes wdata onto the return stack (into TOR). Command 8 drops TOR and replaces it with the entry below it.
- R9: Each array holds 16 entries behind its top register, and its pointer wraps modulo 16. After more than 17 pushes, pops return the newest values in reverse order and then cycle through the array again. No error is raised.
- R10: Command 0 and the unused codes 9 to 15 leave TOS, NOS and TOR unchanged.
- R11: Data-only commands (1 to 4) never change TOR. Return-only commands (7 and 8) never change TOS or NOS.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd | input | 4 | Stack command code for this cycle |
| wdata | input | 16 | Value for push, replace, combined and return-push commands |
| tos | output | 16 | Data stack top register |
| nos | output | 16 | Data stack entry just below the top |
| tor | output | 16 | Return stack top register |

## Verification
The in-RTL assertions check the following properties on every cycle:
- pointer stepping for every command;
- push and pop data movement between the top register and the array;
- the cross-stack moves;
- the reset values;
- output stability under idle codes.

They do not check what the whole array holds over a long history. Only the bench's scenarios can show that:
- deep pushes and pops and the wrap-around order past 17 elements;
- the stacks' isolation from each other over long mixed command streams;
- the NOS value exposed after a combined command.

The bench therefore runs a reference model of both stacks through a long pseudo-random command sweep.

// File: rtl/dstk_pkg.sv
// Package: shared types for the dual stack unit.
// Assumes: command codes are fixed by the block's interface definition.
package dstk_pkg;

    // External command codes (values are part of the interface)
    typedef enum logic [3:0] {
        CMD_NOP     = 4'd0,
        CMD_DPUSH   = 4'd1,
        CMD_DPOP    = 4'd2,
        CMD_DREPL   = 4'd3,
        CMD_DBINOP  = 4'd4,
        CMD_D2R     = 4'd5,
        CMD_R2D     = 4'd6,
        CMD_RPUSH   = 4'd7,
        CMD_RDROP   = 4'd8
    } dstk_cmd_e;

    // Per-lane operation issued by the decoder
    typedef enum logic [2:0] {
        LOP_HOLD    = 3'd0,
        LOP_PUSH    = 3'd1,
        LOP_POP     = 3'd2,
        LOP_LOAD    = 3'd3,
        LOP_POPLOAD = 3'd4
    } lane_op_e;

endpackage

// File: rtl/stack_lane.sv
// Module: stack_lane
// One hardware stack: a cached top register in front of a circular
// register-file array addressed by a hidden wrapping pointer.
// Assumes: DEPTH is a power of two; the array is not cleared by reset.
module stack_lane
    import dstk_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  lane_op_e     op,
    input  logic [W-1:0] din,
    output logic [W-1:0] top,
    output logic [W-1:0] next
);

    localparam int PW = $clog2(DEPTH);
    localparam logic [PW-1:0] PTR_ONE = PW'(1);

    logic [W-1:0]  mem [DEPTH];
    logic [PW-1:0] ptr;
    logic [PW-1:0] ptr_inc;
    logic [PW-1:0] ptr_dec;

    // Neighbouring pointer values, wrapping naturally at PW bits
    always_comb begin
        ptr_inc = ptr + PTR_ONE;
        ptr_dec = ptr - PTR_ONE;
    end

    assign next = mem[ptr];

    // Top register and pointer update for the selected operation
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            top <= '0;
        end else begin
            unique case (op)
                LOP_PUSH: begin
                    ptr <= ptr_inc;
                    top <= din;
                end
                LOP_POP: begin
                    ptr <= ptr_dec;
                    top <= mem[ptr];
                end
                LOP_LOAD: begin
                    top <= din;
                end
                LOP_POPLOAD: begin
                    ptr <= ptr_dec;
                    top <= din;
                end
                default: begin
                    ptr <= ptr;
                    top <= top;
                end
            endcase
        end
    end

    // Spill the old top into the array slot above the current pointer on push
    always_ff @(posedge clk) begin
        if (rst_n && op == LOP_PUSH) begin
            mem[ptr_inc] <= top;
        end
    end

    // R1
    lane_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (top == '0 && ptr == '0));

    // R9
    lane_push_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == LOP_PUSH |=> ptr == $past(ptr) + PTR_ONE);

    // R9
    lane_pop_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == LOP_POP || op == LOP_POPLOAD) |=> ptr == $past(ptr) - PTR_ONE);

    // R2
    lane_push_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == LOP_PUSH |=> (next == $past(top) && top == $past(din)));

    // R3
    lane_pop_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == LOP_POP |=> top == $past(next));

    // R10
    lane_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op == LOP_HOLD |=> ($stable(top) && $stable(ptr)));

endmodule

// File: rtl/stack_cmd_decode.sv
// Module: stack_cmd_decode
// Splits one command code into an operation per stack and the source
// selects for cross-stack moves.
// Assumes: unused codes act as no operation.
module stack_cmd_decode
    import dstk_pkg::*;
(
    input  logic [3:0] cmd,
    output lane_op_e   d_op,
    output lane_op_e   r_op,
    output logic       d_from_ret,
    output logic       r_from_data
);

    // Combinational translation of the command into lane operations
    always_comb begin
        d_op        = LOP_HOLD;
        r_op        = LOP_HOLD;
        d_from_ret  = 1'b0;
        r_from_data = 1'b0;
        case (cmd)
            CMD_DPUSH:  d_op = LOP_PUSH;
            CMD_DPOP:   d_op = LOP_POP;
            CMD_DREPL:  d_op = LOP_LOAD;
            CMD_DBINOP: d_op = LOP_POPLOAD;
            CMD_D2R: begin
                d_op        = LOP_POP;
                r_op        = LOP_PUSH;
                r_from_data = 1'b1;
            end
            CMD_R2D: begin
                d_op       = LOP_PUSH;
                r_op       = LOP_POP;
                d_from_ret = 1'b1;
            end
            CMD_RPUSH:  r_op = LOP_PUSH;
            CMD_RDROP:  r_op = LOP_POP;
            default: begin
                d_op = LOP_HOLD;
                r_op = LOP_HOLD;
            end
        endcase
    end

endmodule

// File: rtl/dual_stack_unit.sv
// Module: dual_stack_unit
// Data stack and return stack with cached tops (TOS, TOR) and wrapping
// hidden pointers; one command per cycle, including cross-stack moves.
// Assumes: no overflow signalling; the caller tracks depth if it matters.
module dual_stack_unit
    import dstk_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [3:0]   cmd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] tos,
    output logic [W-1:0] nos,
    output logic [W-1:0] tor
);

    lane_op_e     d_op;
    lane_op_e     r_op;
    logic         d_from_ret;
    logic         r_from_data;
    logic [W-1:0] d_din;
    logic [W-1:0] r_din;
    logic [W-1:0] r_next;

    stack_cmd_decode u_dec (
        .cmd         (cmd),
        .d_op        (d_op),
        .r_op        (r_op),
        .d_from_ret  (d_from_ret),
        .r_from_data (r_from_data)
    );

    // Route the other stack's top in for transfers, else the write value
    always_comb begin
        d_din = d_from_ret  ? tor : wdata;
        r_din = r_from_data ? tos : wdata;
    end

    stack_lane #(.W(W), .DEPTH(DEPTH)) u_data (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (d_op),
        .din   (d_din),
        .top   (tos),
        .next  (nos)
    );

    stack_lane #(.W(W), .DEPTH(DEPTH)) u_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (r_op),
        .din   (r_din),
        .top   (tor),
        .next  (r_next)
    );

    // R6
    d2r_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_D2R |=> (tor == $past(tos) && tos == $past(nos)));

    // R7
    r2d_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_R2D |=> (tos == $past(tor) && nos == $past(tos)
                            && tor == $past(r_next)));

    // R4
    replace_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd == CMD_DREPL |=> (tos == $past(wdata) && $stable(nos) && $stable(tor)));

    // R11
    data_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd >= CMD_DPUSH && cmd <= CMD_DBINOP) |=> $stable(tor));

    // R11
    ret_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_RPUSH || cmd == CMD_RDROP) |=> ($stable(tos) && $stable(nos)));

    // R10
    idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP || cmd > CMD_RDROP) |=>
            ($stable(tos) && $stable(nos) && $stable(tor)));

endmodule

// File: tb/tb_dual_stack_unit.sv
module tb_dual_stack_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd = 4'd0;
    logic [15:0] wdata = 16'd0;
    logic [15:0] tos, nos, tor;

    int vectors = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic [15:0] dm [16];
    logic [15:0] rm [16];
    bit          dv [16];
    bit          rv [16];
    logic [3:0]  dptr, rptr;
    logic [15:0] mtos, mtor;
    bit          tos_ok, tor_ok;

    always #2 clk = ~clk;  // 250 MHz

    dual_stack_unit dut (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .wdata(wdata),
        .tos(tos), .nos(nos), .tor(tor)
    );

    task automatic cmp(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        if (tos_ok) cmp(tag, "tos", tos, mtos);
        if (tor_ok) cmp(tag, "tor", tor, mtor);
        if (dv[dptr]) cmp(tag, "nos", nos, dm[dptr]);
    endtask

    task automatic m_dpush(input logic [15:0] v);
        dptr = dptr + 4'd1;
        dm[dptr] = mtos; dv[dptr] = tos_ok;
        mtos = v; tos_ok = 1'b1;
    endtask

    task automatic m_dpop();
        mtos = dm[dptr]; tos_ok = dv[dptr];
        dptr = dptr - 4'd1;
    endtask

    task automatic m_rpush(input logic [15:0] v);
        rptr = rptr + 4'd1;
        rm[rptr] = mtor; rv[rptr] = tor_ok;
        mtor = v; tor_ok = 1'b1;
    endtask

    task automatic m_rpop();
        mtor = rm[rptr]; tor_ok = rv[rptr];
        rptr = rptr - 4'd1;
    endtask

    task automatic m_reset();
        dptr = 4'd0; rptr = 4'd0;
        mtos = 16'd0; mtor = 16'd0;
        tos_ok = 1'b1; tor_ok = 1'b1;
    endtask

    // drive one command at a falling edge, update model, check at next falling edge
    task automatic step(input logic [3:0] c, input logic [15:0] d, input string tag);
        logic [15:0] t;
        cmd = c; wdata = d;
        case (c)
            4'd1: m_dpush(d);
            4'd2: m_dpop();
            4'd3: mtos = d;
            4'd4: begin dptr = dptr - 4'd1; mtos = d; tos_ok = 1'b1; end
            4'd5: begin t = mtos; m_dpop(); m_rpush(t); end
            4'd6: begin t = mtor; m_rpop(); m_dpush(t); end
            4'd7: m_rpush(d);
            4'd8: m_rpop();
            default: ;
        endcase
        @(negedge clk);
        check_all(tag);
    endtask

    function automatic string tag_of(input logic [3:0] c);
        case (c)
            4'd1: return "R2";
            4'd2: return "R3";
            4'd3: return "R4";
            4'd4: return "R5";
            4'd5: return "R6";
            4'd6: return "R7";
            4'd7, 4'd8: return "R8";
            default: return "R10";
        endcase
    endfunction

    initial begin
        for (int i = 0; i < 16; i++) begin dv[i] = 1'b0; rv[i] = 1'b0; end
        m_reset();
        repeat (3) @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;

        // fill both arrays so every entry is defined
        for (int i = 0; i < 17; i++) step(4'd1, 16'h1000 + 16'(i), "R2");
        for (int i = 0; i < 17; i++) step(4'd7, 16'h2000 + 16'(i), "R8");

        // directed: each command once with distinct values
        step(4'd1, 16'hA5A5, "R2");
        step(4'd3, 16'h5A5A, "R4");
        step(4'd4, 16'h0F0F, "R5");
        step(4'd2, 16'h0000, "R3");
        step(4'd5, 16'h0000, "R6");
        step(4'd6, 16'h0000, "R7");
        step(4'd8, 16'h0000, "R8");
        step(4'd0, 16'hFFFF, "R10");
        step(4'd12, 16'hFFFF, "R10");
        step(4'd1, 16'h1111, "R11");
        step(4'd7, 16'h2222, "R11");

        // wrap: 20 pushes then 20 pops, values follow circular order
        for (int i = 0; i < 20; i++) step(4'd1, 16'h3000 + 16'(i), "R9");
        for (int i = 0; i < 20; i++) step(4'd2, 16'h0000, "R9");
        for (int i = 0; i < 20; i++) step(4'd5, 16'h0000, "R9");
        for (int i = 0; i < 20; i++) step(4'd6, 16'h0000, "R9");

        // mid-run reset
        cmd = 4'd0; rst_n = 1'b0;
        m_reset();
        @(negedge clk);
        check_all("R1");
        rst_n = 1'b1;
        step(4'd1, 16'h4444, "R1");
        step(4'd2, 16'h0000, "R1");

        // pseudo-random sweep over every code
        begin
            logic [15:0] lfsr = 16'hACE1;
            for (int i = 0; i < 6000; i++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                step(lfsr[3:0], {lfsr[7:0], lfsr[15:8]}, tag_of(lfsr[3:0]));
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule